// File: doc/BRIEF.md
# Test Access Port with Switchable TDO Launch Edge

This block is a serial debug test access port. It runs the standard 16-state TAP controller, clocked by TCK and steered by TMS. Its instruction register selects one of three data paths: a single-bit bypass, a 32-bit device identifier, or a one-bit readback of the current TDO timing mode. Serial data enters on TDI and leaves on TDO. The output is enabled only while one of the two shift states is active.

After any reset, TDO launches each bit on the falling edge of TCK. A host that wants more setup margin at its own sampling point can load the timing-switch opcode. From the Update-IR edge onward, TDO launches on the rising edge. The setting survives later instruction loads. Only an asynchronous active-low reset, or passing through Test-Logic-Reset, returns the output to falling-edge launch.

Top module: `jtag_tap`

## Requirements
- R1: The controller follows the standard TAP state diagram under TMS at each rising TCK edge. Five rising edges with TMS high bring it to Test-Logic-Reset from any state. Test-Logic-Reset loads the instruction register with 8'hFF (bypass).
- R2: While trst_n is low, the controller is held in Test-Logic-Reset, the instruction register holds 8'hFF, the timing mode is falling-edge, and tdo_oe and tdo are 0. None of this waits for a TCK edge.
- R3: Capture-IR loads 8'b0000_0001 into the IR shift stage. Shift-IR moves that stage toward TDO least significant bit first, with TDI entering at the most significant bit. Update-IR latches the stage as the active instruction.
- R4: Instruction 8'hFF, and any opcode other than 8'h01 and 8'h5A, selects the one-bit bypass path. Bypass captures 0, and each TDI bit appears on TDO one shift later.
- R5: Instruction 8'h01 selects the 32-bit identifier. The identifier is captured in Capture-DR and shifted out least significant bit first.
- R6: tdo_oe is 1 only for shifts in Shift-IR or Shift-DR. Whenever tdo_oe is 0, tdo is 0.
- R7: In the default mode, tdo and tdo_oe change on the falling TCK edge. A bit is therefore still held through the rising edge that shifts it out.
- R8: Latching opcode 8'h5A in Update-IR switches tdo and tdo_oe to change right after the rising TCK edge. This applies from the very next shift, including a shift reached through Select-DR without visiting Run-Test/Idle. The mode is kept when other instructions are loaded later.
- R9: Entering Test-Logic-Reset returns the launch mode to falling-edge.
- R10: With instruction 8'h5A active, the data path is one bit. Capture-DR loads the current mode into it: 1 for rising-edge launch, 0 for falling-edge launch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; state and shift registers advance on its rising edge |
| trst_n | input | 1 | Asynchronous active-low reset of the whole port |
| tms | input | 1 | Mode select sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK during shifts |
| tdo | output | 1 | Serial data out, 0 when not enabled |
| tdo_oe | output | 1 | Output enable for tdo, high only in the shift states |

## Verification
Two things can meet on a single rising TCK edge: the Update-IR edge that latches the timing-switch opcode, and the start of the next data shift. The shortest route from Update-IR goes through Select-DR and Capture-DR into Shift-DR. The bench takes that route straight after loading 8'h5A. It then samples tdo_oe and tdo just after the rising edge that enters Shift-DR. Rising-edge launch must already be visible there: the enable is high and the readback bit is 1. Under falling-edge launch, both would still be 0 at that sampling point.

// File: rtl/jtag_tap_pkg.sv
`timescale 1ns/1ps
package jtag_tap_pkg;

    localparam int IR_W = 8;

    localparam logic [IR_W-1:0] OP_IDCODE   = 8'h01;
    localparam logic [IR_W-1:0] OP_EDGE_SW  = 8'h5A;
    localparam logic [IR_W-1:0] OP_BYPASS   = 8'hFF;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 8'b0000_0001;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UP_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UP_IR
    } tap_state_e;

    typedef enum logic [1:0] { DR_BYPASS, DR_IDCODE, DR_EDGE } dr_sel_e;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        case (s)
            ST_TLR:    return m ? ST_TLR    : ST_RTI;
            ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return m ? ST_UP_DR  : ST_PA_DR;
            ST_PA_DR:  return m ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: return m ? ST_UP_DR  : ST_SH_DR;
            ST_UP_DR:  return m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return m ? ST_UP_IR  : ST_PA_IR;
            ST_PA_IR:  return m ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: return m ? ST_UP_IR  : ST_SH_IR;
            ST_UP_IR:  return m ? ST_SEL_DR : ST_RTI;
            default:   return ST_TLR;
        endcase
    endfunction

    function automatic dr_sel_e dr_select(input logic [IR_W-1:0] op);
        case (op)
            OP_IDCODE:  return DR_IDCODE;
            OP_EDGE_SW: return DR_EDGE;
            default:    return DR_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
`timescale 1ns/1ps
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= tap_next(state, tms);
    end

    // Consecutive-TMS-high counter, used only by the checks below.
    logic [2:0] ones_q;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)            ones_q <= '0;
        else if (!tms)          ones_q <= '0;
        else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
    end

    // R1
    five_ones_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q == 3'd5) |-> (state == ST_TLR));

    // R1
    tlr_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR && tms) |=> (state == ST_TLR));

endmodule

// File: rtl/jtag_tap_ir.sv
`timescale 1ns/1ps
module jtag_tap_ir
    import jtag_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir,
    output logic            ir_so,
    output logic            edge_rise
);

    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sr <= IR_CAPTURE;
        end else if (state == ST_CAP_IR) begin
            ir_sr <= IR_CAPTURE;
        end else if (state == ST_SH_IR) begin
            ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                ir <= OP_BYPASS;
        else if (state == ST_TLR)   ir <= OP_BYPASS;
        else if (state == ST_UP_IR) ir <= ir_sr;
    end

    // Launch-edge mode: sticky once set, cleared only by reset paths.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                                        edge_rise <= 1'b0;
        else if (state == ST_TLR)                           edge_rise <= 1'b0;
        else if (state == ST_UP_IR && ir_sr == OP_EDGE_SW)  edge_rise <= 1'b1;
    end

    assign ir_so = ir_sr[0];

    // R8
    edge_set_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(edge_rise) |-> ($past(state) == ST_UP_IR && $past(ir_sr) == OP_EDGE_SW));

    // R9
    edge_clear_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR) |=> !edge_rise);

    // R1
    ir_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR) |=> (ir == OP_BYPASS));

endmodule

// File: rtl/jtag_tap_dr.sv
`timescale 1ns/1ps
module jtag_tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int              ID_W   = 32,
    parameter logic [ID_W-1:0] ID_VAL = 32'h4B2D_19A3
) (
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    input  logic [IR_W-1:0] ir,
    input  logic            edge_rise,
    output logic            dr_so
);

    logic [ID_W-1:0] id_sr;
    logic            byp_sr;
    logic            edg_sr;
    dr_sel_e         sel;

    assign sel = dr_select(ir);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            id_sr  <= '0;
            byp_sr <= 1'b0;
            edg_sr <= 1'b0;
        end else if (state == ST_CAP_DR) begin
            id_sr  <= ID_VAL;
            byp_sr <= 1'b0;
            edg_sr <= edge_rise;
        end else if (state == ST_SH_DR) begin
            id_sr  <= {tdi, id_sr[ID_W-1:1]};
            byp_sr <= tdi;
            edg_sr <= tdi;
        end
    end

    always_comb begin
        case (sel)
            DR_IDCODE: dr_so = id_sr[0];
            DR_EDGE:   dr_so = edg_sr;
            default:   dr_so = byp_sr;
        endcase
    end

endmodule

// File: rtl/jtag_tap.sv
`timescale 1ns/1ps
module jtag_tap
    import jtag_tap_pkg::*;
#(
    parameter int              ID_W   = 32,
    parameter logic [ID_W-1:0] ID_VAL = 32'h4B2D_19A3
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe
);

    tap_state_e      state;
    logic [IR_W-1:0] ir;
    logic            ir_so;
    logic            dr_so;
    logic            edge_rise;

    jtag_tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
    );

    jtag_tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
        .ir(ir), .ir_so(ir_so), .edge_rise(edge_rise)
    );

    jtag_tap_dr #(.ID_W(ID_W), .ID_VAL(ID_VAL)) u_dr (
        .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
        .ir(ir), .edge_rise(edge_rise), .dr_so(dr_so)
    );

    logic shifting;
    logic so_bit;
    assign shifting = (state == ST_SH_IR) || (state == ST_SH_DR);
    assign so_bit   = (state == ST_SH_IR) ? ir_so : dr_so;

    // Falling-edge launch stage.
    logic tdo_neg, oe_neg;
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_neg <= 1'b0;
            oe_neg  <= 1'b0;
        end else begin
            tdo_neg <= shifting & so_bit;
            oe_neg  <= shifting;
        end
    end

    // Rising-edge launch follows the registers updated at the rising edge.
    assign tdo    = edge_rise ? (shifting & so_bit) : tdo_neg;
    assign tdo_oe = edge_rise ? shifting            : oe_neg;

    // R6
    oe_shift_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

    // R6
    tdo_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_oe |-> !tdo);

endmodule

// File: tb/tb_jtag_tap.sv
`timescale 1ns/1ps
module tb_jtag_tap;

    localparam logic [31:0] ID = 32'h4B2D_19A3;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo, tdo_oe;

    int checks = 0;
    int errors = 0;

    logic e_tdo, e_oe, l_tdo, l_oe;

    jtag_tap #(.ID_W(32), .ID_VAL(ID)) dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe)
    );

    always #4 tck = ~tck;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One TCK period starting at posedge+1: sample early, drive, sample before next rise.
    task automatic tick(input logic m, input logic d);
        e_tdo = tdo; e_oe = tdo_oe;
        tms = m; tdi = d;
        @(negedge tck); #3;
        l_tdo = tdo; l_oe = tdo_oe;
        @(posedge tck); #1;
    endtask

    task automatic go_idle();
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    task automatic load_ir(input logic [7:0] op, output logic [7:0] cap);
        tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            tick(i == 7, op[i]);
            cap[i] = l_tdo;
        end
        tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    endtask

    task automatic shift_dr(input int n, input logic [63:0] din,
                            output logic [63:0] dout, output logic [63:0] etdo,
                            output logic [63:0] eoe);
        dout = '0; etdo = '0; eoe = '0;
        tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i]);
            dout[i] = l_tdo; etdo[i] = e_tdo; eoe[i] = e_oe;
        end
        tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    endtask

    task automatic t_reset();
        chk(tdo_oe == 1'b0 && tdo == 1'b0, "R2 reset outputs", {tdo_oe, tdo}, 0);
        @(posedge tck); #1;
        trst_n = 1'b1;
        go_idle();
        chk(tdo_oe == 1'b0, "R6 idle oe", tdo_oe, 0);
    endtask

    task automatic t_ir_capture();
        logic [7:0] cap;
        load_ir(8'h01, cap);
        chk(cap == 8'h01, "R3 IR capture pattern", cap, 8'h01);
        load_ir(8'hFF, cap);
    endtask

    task automatic t_bypass(input logic [7:0] op);
        logic [7:0] cap;
        logic [63:0] o, et, eo;
        load_ir(op, cap);
        shift_dr(8, 64'hA5, o, et, eo);
        chk(o[7:0] == 8'h4A, "R4 bypass delay", o[7:0], 8'h4A);
        chk(eo[0] == 1'b0, "R7 oe not yet launched after rise", eo[0], 0);
    endtask

    task automatic t_idcode_falling();
        logic [7:0] cap;
        logic [63:0] o, et, eo, exp;
        load_ir(8'h01, cap);
        shift_dr(32, 64'h0, o, et, eo);
        chk(o[31:0] == ID, "R5 IDCODE shift", o[31:0], ID);
        exp = {31'h0, ID, 1'b0};
        chk(et[31:0] == exp[31:0], "R7 falling launch early samples", et[31:0], exp[31:0]);
        chk(eo[31:0] == 32'hFFFF_FFFE, "R7 falling oe timing", eo[31:0], 32'hFFFF_FFFE);
    endtask

    task automatic t_switch_fast();
        logic [7:0] cap;
        tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) tick(i == 7, OP_SW[i]);
        tick(1'b1, 1'b0);            // Update-IR
        tick(1'b1, 1'b0);            // Select-DR, Idle skipped
        tick(1'b0, 1'b0);            // Capture-DR
        tick(1'b0, 1'b0);            // enters Shift-DR
        tick(1'b1, 1'b0);            // single shift, exit
        chk(e_oe == 1'b1, "R8 rising launch on first shift", e_oe, 1);
        chk(e_tdo == 1'b1, "R10 edge readback", e_tdo, 1);
        tick(1'b1, 1'b0); tick(1'b0, 1'b0);
        cap = 8'h0;
    endtask

    localparam logic [7:0] OP_SW = 8'h5A;

    task automatic t_idcode_rising();
        logic [7:0] cap;
        logic [63:0] o, et, eo;
        load_ir(8'h01, cap);
        shift_dr(32, 64'h0, o, et, eo);
        chk(o[31:0] == ID, "R5 IDCODE in rising mode", o[31:0], ID);
        chk(et[31:0] == ID, "R8 rising launch persists", et[31:0], ID);
        chk(eo[31:0] == 32'hFFFF_FFFF, "R8 rising oe timing", eo[31:0], 32'hFFFF_FFFF);
    endtask

    task automatic t_tlr_clears();
        logic [7:0] cap;
        logic [63:0] o, et, eo;
        go_idle();
        load_ir(OP_SW, cap);
        // Capture with the switch opcode already active: bit must read 1 again.
        shift_dr(1, 64'h0, o, et, eo);
        chk(o[0] == 1'b1, "R10 readback rising", o[0], 1);
        go_idle();
        load_ir(8'h01, cap);
        shift_dr(32, 64'h0, o, et, eo);
        chk(eo[0] == 1'b0, "R9 TLR restores falling launch", eo[0], 0);
    endtask

    task automatic t_five_ones(input int len, input logic [15:0] seq, input string tag);
        logic [7:0] cap;
        logic [63:0] o, et, eo;
        go_idle();
        load_ir(8'h01, cap);
        for (int i = 0; i < len; i++) tick(seq[i], 1'b0);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        shift_dr(2, 64'h3, o, et, eo);
        chk(o[1:0] == 2'b10, {"R1 five TMS high from ", tag}, o[1:0], 2'b10);
    endtask

    task automatic t_async_trst();
        logic [63:0] o, et, eo;
        logic [7:0] cap;
        load_ir(OP_SW, cap);
        load_ir(8'h01, cap);
        tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
        chk(tdo_oe == 1'b1, "R8 shifting before trst", tdo_oe, 1);
        trst_n = 1'b0;
        #1;
        chk(tdo_oe == 1'b0 && tdo == 1'b0, "R2 async trst drops outputs", {tdo_oe, tdo}, 0);
        @(posedge tck); #1;
        trst_n = 1'b1;
        tick(1'b0, 1'b0);
        shift_dr(2, 64'h3, o, et, eo);
        chk(o[1:0] == 2'b10, "R2 IR back to bypass", o[1:0], 2'b10);
        chk(eo[0] == 1'b0, "R2 falling launch after trst", eo[0], 0);
    endtask

    initial begin
        #(200000 * 8);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge tck);
        #1;
        t_reset();
        t_ir_capture();
        t_bypass(8'hFF);
        t_bypass(8'h33);
        t_idcode_falling();
        t_switch_fast();
        t_idcode_rising();
        t_tlr_clears();
        t_five_ones(0, 16'h0, "Run-Test/Idle");
        t_five_ones(3, 16'h0001, "Shift-DR");
        t_five_ones(6, 16'h0013, "Pause-IR");
        t_five_ones(6, 16'h0029, "Exit2-DR");
        t_five_ones(6, 16'h0033, "Update-IR");
        t_async_trst();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule